// File: doc/BRIEF.md
# Double-Action Output Compare Channel

This block is one channel of a timer that drives a single output pin with pulses of variable width. Two comparators watch a counter bus that the channel shares with others. A match on comparator A drives the output to the polarity level, which starts the pulse. A match on comparator B drives it to the opposite level, which ends the pulse. The two matches may come in either order. Each comparator fires once per load. Software loads it again by writing its staging register, and the channel moves that value into the comparator's active register on the next clock.

An update-hold input freezes these staging-to-active moves, so that several channels can be reloaded together. Two force strobes set the pin directly to the level that an A match or a B match would produce. An event flag records matches. A flag-mode input chooses whether both matches set the flag or only B matches do. Writing a one to the flag-clear input clears the flag. The mode-enable input takes the channel in and out of this mode. Each time the channel enters the mode it starts from a known, disarmed state.

Top module: `dacp_channel`

## Requirements
- R1: After the synchronous reset, `pulse_out` is 0 and `flag_out` is 0. Both comparators are disarmed, so a counter value equal to an active register has no effect until a staging write has been transferred.
- R2: On any clock edge where `mode_en` is low, both comparators are disarmed, any pending staging write is dropped, and `pulse_out` is loaded with the inverse of `pol`. Staging writes made while `mode_en` is low are ignored.
- R3: A staging write to A or B is accepted on one clock edge. It is copied into the active register, and arms that comparator, on the next clock edge on which `upd_hold` is low. While `upd_hold` is high the write stays pending, and it transfers on the first edge after `upd_hold` falls.
- R4: An armed comparator matches when `cnt_bus` equals its active register. The match takes effect on that clock edge, and the comparator then disarms. Later equal counter values have no effect until the next transfer. A and B arm and disarm independently.
- R5: An armed A match drives `pulse_out` to `pol`, and an armed B match drives it to the inverse of `pol`, in either order. When both match on the same edge, the B level wins.
- R6: With `flag_both` = 1, an armed A match or an armed B match sets `flag_out`. With `flag_both` = 0, only an armed B match sets it. A disarmed comparator never sets it.
- R7: A high `flag_clr` clears `flag_out` on the next edge. If a flag-setting match happens on the same edge, the flag is set instead.
- R8: `force_a` drives `pulse_out` to `pol`, and `force_b` drives it to the inverse of `pol`. B wins when both are high. Neither strobe changes `flag_out`.
- R9: After a comparator is loaded again, each new armed match still drives `pulse_out`, whatever the state of `flag_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | High while the channel is in double-action compare mode |
| cnt_bus | input | CNT_W | Shared counter value |
| pol | input | 1 | Level driven by an A event |
| flag_both | input | 1 | 1: A and B matches set the flag; 0: only B matches |
| upd_hold | input | 1 | High blocks staging-to-active transfers |
| a_wr | input | 1 | Write strobe for staging register A |
| a_data | input | CNT_W | Data for staging register A |
| b_wr | input | 1 | Write strobe for staging register B |
| b_data | input | CNT_W | Data for staging register B |
| force_a | input | 1 | Force the A-event level on the output |
| force_b | input | 1 | Force the B-event level on the output |
| flag_clr | input | 1 | Write-one-to-clear for the flag |
| pulse_out | output | 1 | Registered pulse output |
| flag_out | output | 1 | Registered event flag |

## Verification
Arming is hidden state, and it shows at the ports only when the counter passes the loaded value. A comparator left armed by mistake makes a second edge appear on `pulse_out` when the counter wraps. A comparator that never armed leaves the output flat. Either fault appears within one counter period after the transfer. A lost or early transfer under `upd_hold` moves the pulse edge to the wrong counter value. The bench therefore sweeps every A and B value of a narrow counter through two full periods, for both polarities and both flag modes. It checks the output and the flag after every edge.

// File: rtl/dacp_pkg.sv
package dacp_pkg;
  localparam int NUM_CMP = 2;
  localparam int CMP_A   = 0;
  localparam int CMP_B   = 1;

  typedef struct packed {
    logic hit;
    logic armed;
  } cmp_stat_t;
endpackage

// File: rtl/dacp_cmp.sv
module dacp_cmp #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_en,
  input  logic             hold,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cnt,
  output dacp_pkg::cmp_stat_t stat
);
  logic [CNT_W-1:0] stage_q;
  logic [CNT_W-1:0] active_q;
  logic             pend_q;
  logic             armed_q;
  logic             xfer;
  logic             hit;

  assign xfer = mode_en && pend_q && !hold;
  assign hit  = armed_q && (cnt == active_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      active_q <= '0;
      pend_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else if (!mode_en) begin
      pend_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      if (wr) begin
        stage_q <= wr_data;
        pend_q  <= 1'b1;
      end else if (xfer) begin
        pend_q  <= 1'b0;
      end
      if (xfer) begin
        active_q <= stage_q;
        armed_q  <= 1'b1;
      end else if (hit) begin
        armed_q  <= 1'b0;
      end
    end
  end

  assign stat.hit   = hit;
  assign stat.armed = armed_q;

  // R3
  hold_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_en && hold && pend_q) |=> pend_q);
  // R3
  hold_freezes_active_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(active_q));
  // R4
  arm_only_on_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(xfer));
  // R4
  single_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !xfer) |=> !armed_q);
  // R2
  mode_exit_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> (!armed_q && !pend_q));
endmodule

// File: rtl/dacp_outflag.sv
module dacp_outflag (
  input  logic clk,
  input  logic rst,
  input  logic mode_en,
  input  logic pol,
  input  logic flag_both,
  input  logic hit_a,
  input  logic hit_b,
  input  logic force_a,
  input  logic force_b,
  input  logic flag_clr,
  output logic out_q,
  output logic flag_q
);
  logic set_ev;

  assign set_ev = mode_en && (hit_b || (flag_both && hit_a));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
    end else if (!mode_en) begin
      out_q <= !pol;
    end else if (hit_b || force_b) begin
      out_q <= !pol;
    end else if (hit_a || force_a) begin
      out_q <= pol;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (set_ev)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  // R2
  entry_level_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> (out_q == !$past(pol)));
  // R5
  b_level_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_en && hit_b) |=> (out_q == !$past(pol)));
  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_en && hit_b) |=> flag_q);
  // R8
  force_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_en && (force_a || force_b) && !hit_a && !hit_b && !flag_q) |=> !flag_q);
endmodule

// File: rtl/dacp_channel.sv
module dacp_channel #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_en,
  input  logic [CNT_W-1:0] cnt_bus,
  input  logic             pol,
  input  logic             flag_both,
  input  logic             upd_hold,
  input  logic             a_wr,
  input  logic [CNT_W-1:0] a_data,
  input  logic             b_wr,
  input  logic [CNT_W-1:0] b_data,
  input  logic             force_a,
  input  logic             force_b,
  input  logic             flag_clr,
  output logic             pulse_out,
  output logic             flag_out
);
  import dacp_pkg::*;

  logic [NUM_CMP-1:0]            wr_vec;
  logic [NUM_CMP-1:0][CNT_W-1:0] data_vec;
  cmp_stat_t                     stat [NUM_CMP];

  assign wr_vec[CMP_A]   = a_wr;
  assign wr_vec[CMP_B]   = b_wr;
  assign data_vec[CMP_A] = a_data;
  assign data_vec[CMP_B] = b_data;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    dacp_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst     (rst),
      .mode_en (mode_en),
      .hold    (upd_hold),
      .wr      (wr_vec[i]),
      .wr_data (data_vec[i]),
      .cnt     (cnt_bus),
      .stat    (stat[i])
    );
  end

  dacp_outflag u_outflag (
    .clk       (clk),
    .rst       (rst),
    .mode_en   (mode_en),
    .pol       (pol),
    .flag_both (flag_both),
    .hit_a     (stat[CMP_A].hit),
    .hit_b     (stat[CMP_B].hit),
    .force_a   (force_a),
    .force_b   (force_b),
    .flag_clr  (flag_clr),
    .out_q     (pulse_out),
    .flag_q    (flag_out)
  );
endmodule

// File: tb/tb_dacp_channel.sv
module tb_dacp_channel;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_en = 1'b0;
  logic [W-1:0] cnt_bus = '0;
  logic pol = 1'b0, flag_both = 1'b0, upd_hold = 1'b0;
  logic a_wr = 1'b0, b_wr = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic force_a = 1'b0, force_b = 1'b0, flag_clr = 1'b0;
  logic pulse_out, flag_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dacp_channel #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .mode_en(mode_en), .cnt_bus(cnt_bus), .pol(pol),
    .flag_both(flag_both), .upd_hold(upd_hold), .a_wr(a_wr), .a_data(a_data),
    .b_wr(b_wr), .b_data(b_data), .force_a(force_a), .force_b(force_b),
    .flag_clr(flag_clr), .pulse_out(pulse_out), .flag_out(flag_out)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic enter(input logic p);
    mode_en = 1'b0; pol = p; flag_clr = 1'b1;
    step();
    chk(pulse_out, ~p, "R2 entry level");
    chk(flag_out, 1'b0, "R7 clear");
    mode_en = 1'b1; flag_clr = 1'b0;
  endtask

  task automatic load(input logic wa, input logic [W-1:0] va,
                      input logic wb, input logic [W-1:0] vb);
    a_wr = wa; a_data = va; b_wr = wb; b_data = vb;
    step();
    a_wr = 1'b0; b_wr = 1'b0;
  endtask

  task automatic flat_sweep(input logic eo, input logic ef, input string req);
    for (int k = 0; k < N; k++) begin
      cnt_bus = k[W-1:0];
      step();
      chk(pulse_out, eo, req);
      chk(flag_out, ef, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    chk(pulse_out, 1'b0, "R1 reset out");
    chk(flag_out, 1'b0, "R1 reset flag");
    mode_en = 1'b1; pol = 1'b1; flag_both = 1'b1;
    rst = 1'b0;
    flat_sweep(1'b0, 1'b0, "R1 disarmed after reset");

    for (int p = 0; p < 2; p++)
      for (int fb = 0; fb < 2; fb++)
        for (int a = 0; a < N; a++)
          for (int b = 0; b < N; b++) begin
            logic ep, ef, lp;
            flag_both = fb[0];
            enter(p[0]);
            load(1'b1, a[W-1:0], 1'b1, b[W-1:0]);
            cnt_bus = '0;
            step();
            lp = p[0];
            for (int k = 0; k < N; k++) begin
              cnt_bus = k[W-1:0];
              step();
              if (a <= k && b <= k) ep = (a > b) ? lp : ~lp;
              else if (a <= k)      ep = lp;
              else                  ep = ~lp;
              ef = (b <= k) || (fb == 1 && a <= k);
              chk(pulse_out, ep, "R5 R4 pulse level");
              chk(flag_out, ef, "R6 flag mode");
            end
            ep = (a > b) ? lp : ~lp;
            flat_sweep(ep, 1'b1, "R4 single shot");
          end

    // R3 held transfer, released later
    flag_both = 1'b0;
    enter(1'b1);
    upd_hold = 1'b1;
    load(1'b1, 4'd5, 1'b0, '0);
    flat_sweep(1'b0, 1'b0, "R3 held");
    upd_hold = 1'b0;
    cnt_bus = 4'd5;
    step();
    chk(pulse_out, 1'b0, "R3 transfer edge not armed yet");
    cnt_bus = 4'd4; step();
    chk(pulse_out, 1'b0, "R3 before match");
    cnt_bus = 4'd5; step();
    chk(pulse_out, 1'b1, "R3 pending transfer after release");

    // R2 writes ignored while mode low
    mode_en = 1'b0; pol = 1'b0; a_wr = 1'b1; a_data = 4'd3; b_wr = 1'b1; b_data = 4'd7;
    step();
    a_wr = 1'b0; b_wr = 1'b0; mode_en = 1'b1;
    step();
    flat_sweep(1'b1, 1'b0, "R2 writes ignored");

    // R7 set wins over clear
    enter(1'b0);
    flag_both = 1'b0;
    load(1'b0, '0, 1'b1, 4'd3);
    step();
    for (int k = 0; k < 5; k++) begin
      cnt_bus = k[W-1:0];
      flag_clr = (k == 3);
      step();
    end
    flag_clr = 1'b0;
    chk(flag_out, 1'b1, "R7 set wins");
    chk(pulse_out, 1'b1, "R5 B level");

    // R9 pulses continue with flag set
    load(1'b1, 4'd2, 1'b1, 4'd6);
    step();
    cnt_bus = 4'd2; step();
    chk(pulse_out, 1'b0, "R9 A edge with flag set");
    cnt_bus = 4'd6; step();
    chk(pulse_out, 1'b1, "R9 B edge with flag set");
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    chk(flag_out, 1'b0, "R7 clear");

    // R8 force strobes
    enter(1'b1);
    cnt_bus = '0;
    force_a = 1'b1; step(); force_a = 1'b0;
    chk(pulse_out, 1'b1, "R8 force A");
    chk(flag_out, 1'b0, "R8 force A flag");
    force_b = 1'b1; step(); force_b = 1'b0;
    chk(pulse_out, 1'b0, "R8 force B");
    chk(flag_out, 1'b0, "R8 force B flag");
    force_a = 1'b1; step();
    chk(pulse_out, 1'b1, "R8 force A again");
    force_b = 1'b1; step(); force_a = 1'b0; force_b = 1'b0;
    chk(pulse_out, 1'b0, "R8 force both B wins");
    chk(flag_out, 1'b0, "R8 force both flag");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule